// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Router

This block collects a bank of shared device interrupt lines and a private pending bank for each of up to sixteen processors. For every processor it works out the highest pending interrupt level, between 0 and 15, and presents that level as a group of level lines of which at most one is high. Level 0 means that no interrupt is pending, and no line is raised for it.

Each shared source has a fixed level, taken from a parameter map. The whole set of shared sources goes to a single target processor that software selects. A disable mask hides individual sources, and its top bit turns off every shared source at once. Each processor also has private soft bits and one local timer bit, and these give that processor a level no matter which processor is the target.

Software programs the block through a single-cycle write port. The port carries an operation code, a processor number and a data word. The block is meant to sit between the device interrupt wiring and the interrupt inputs of the processors.

Top module: `irq_level_router`

## Requirements
- R1: While `rst_n` is low, and after it is released, all level lines are 0, the target processor is 0, the disable mask is 0 and every pending bit is clear.
- R2: A shared source line `src_in[s]` raises a pending bit whose level is the mapped level of that source. With the default map this level is `s % 16`. A source mapped to level 0 (by default sources 0 and 16) has no effect.
- R3: Write operation 0 loads `wr_data` into the disable mask. Only shared sources whose mask bit is 0 count toward a level.
- R4: While bit 31 of the disable mask is 1, no shared source contributes a level to any processor.
- R5: Write operation 1 loads `wr_data[3:0]` as the target processor. Shared sources count only for the target. A target at or above `NUM_CPU` routes the shared sources to no processor.
- R6: Write operation 2 sets, and operation 3 clears, the private bits of processor `wr_cpu`, wherever `wr_data[31:17]` is 1. Private bit j gives level j-16. The output level of a processor is the maximum of its private level and, if it is the target, the shared level.
- R7: Input `tmr_in[c]` drives private bit `TIMER_BIT` of processor c (default 30, which is level 14). Soft set and soft clear writes have no effect on that bit.
- R8: Line l of processor c is `lvl_out[c*16+l]`. At most one line per processor is high. Line 0 is never high, and a level of 0 raises no line.
- R9: The levels follow deassertions as well as assertions: removing a source or a private bit lowers the level to the highest one still pending.
- R10: An input or write sampled at clock edge k appears on `lvl_out` after edge k+1.
- R11: Soft set and soft clear writes with `wr_cpu` at or above `NUM_CPU` change no processor's level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | NUM_SRC | Shared device interrupt levels |
| tmr_in | input | NUM_CPU | Local timer level for each processor |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | 0 mask, 1 target, 2 soft set, 3 soft clear |
| wr_cpu | input | CPU_W | Processor selected by soft writes |
| wr_data | input | NUM_SRC | Write data |
| lvl_out | output | NUM_CPU*16 | Level lines, 16 for each processor |

## Verification
Two things can happen in the same cycle: a change of shared source and a change of routing, meaning a new target or a new mask. Such a change can both raise a shared level and move that level to a different processor, while private soft and timer bits change alongside it. The bench provokes these collisions with a pseudo-random phase that changes sources, timers and one write at every cycle. It judges each cycle against a behavioural model that applies all of that cycle's updates together and derives the level of every processor from them.

// File: rtl/irq_rtr_pkg.sv
package irq_rtr_pkg;

   typedef enum logic [1:0] {
      OP_MASK     = 2'd0,
      OP_TARGET   = 2'd1,
      OP_SOFT_SET = 2'd2,
      OP_SOFT_CLR = 2'd3
   } wr_op_e;

   // index of the highest set bit, 0 when none
   function automatic int oh_to_idx(input logic [31:0] oh);
      int r;
      r = 0;
      for (int i = 0; i < 32; i++)
         if (oh[i]) r = i;
      return r;
   endfunction

endpackage

// File: rtl/irq_max_level.sv
module irq_max_level #(
   parameter int LVL_W = 4
) (
   input  logic [(1<<LVL_W)-1:1] req_i,
   output logic [LVL_W-1:0]      lvl_o
);
   localparam int NUM_LVL = 1 << LVL_W;

   always_comb begin
      lvl_o = '0;
      for (int l = 1; l < NUM_LVL; l++)
         if (req_i[l]) lvl_o = LVL_W'(l);
   end
endmodule

// File: rtl/irq_shared_path.sv
module irq_shared_path #(
   parameter int                     NUM_SRC         = 32,
   parameter int                     LVL_W           = 4,
   parameter bit                     USE_DEFAULT_MAP = 1'b1,
   parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVEL_MAP = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               mask_we_i,
   input  logic [NUM_SRC-1:0] wr_data_i,
   output logic [LVL_W-1:0]   shr_lvl_o
);
   localparam int NUM_LVL = 1 << LVL_W;
   localparam int MSTR    = NUM_SRC - 1;

   logic [LVL_W-1:0]   src_lvl [NUM_SRC];
   logic [NUM_SRC-1:0] live;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] eff;
   logic [NUM_LVL-1:1] req;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
      if (USE_DEFAULT_MAP) begin : g_def
         assign src_lvl[s] = LVL_W'(s % NUM_LVL);
      end else begin : g_prm
         assign src_lvl[s] = SRC_LEVEL_MAP[s*LVL_W +: LVL_W];
      end
      assign live[s] = src_i[s] && (src_lvl[s] != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
      end else begin
         pend_q <= live;
         if (mask_we_i) mask_q <= wr_data_i;
      end
   end

   assign eff = pend_q & ~mask_q;

   always_comb begin
      req = '0;
      if (!mask_q[MSTR]) begin
         for (int l = 1; l < NUM_LVL; l++)
            for (int s = 0; s < NUM_SRC; s++)
               if (eff[s] && (src_lvl[s] == LVL_W'(l))) req[l] = 1'b1;
      end
   end

   irq_max_level #(.LVL_W(LVL_W)) u_enc (.req_i(req), .lvl_o(shr_lvl_o));

   // R4: master disable silences the shared encoder
   a_r4_master_off: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q[MSTR] |-> (shr_lvl_o == '0));

endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank #(
   parameter int LVL_W     = 4,
   parameter int TIMER_LVL = 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tmr_i,
   input  logic                  soft_set_i,
   input  logic                  soft_clr_i,
   input  logic [(1<<LVL_W)-1:1] soft_data_i,
   input  logic                  is_tgt_i,
   input  logic [LVL_W-1:0]      shr_lvl_i,
   output logic [(1<<LVL_W)-1:0] lvl_oh_o
);
   import irq_rtr_pkg::*;
   localparam int NUM_LVL = 1 << LVL_W;

   logic [NUM_LVL-1:1] priv_q;
   logic [NUM_LVL-1:1] priv_d;
   logic [LVL_W-1:0]   priv_lvl;
   logic [LVL_W-1:0]   fin_lvl;
   logic [NUM_LVL-1:0] oh_d;

   always_comb begin
      priv_d = priv_q;
      if (soft_set_i) priv_d = priv_d | soft_data_i;
      if (soft_clr_i) priv_d = priv_d & ~soft_data_i;
      priv_d[TIMER_LVL] = tmr_i;
   end

   irq_max_level #(.LVL_W(LVL_W)) u_enc (.req_i(priv_q), .lvl_o(priv_lvl));

   assign fin_lvl = (is_tgt_i && (shr_lvl_i > priv_lvl)) ? shr_lvl_i : priv_lvl;

   always_comb begin
      oh_d = '0;
      for (int l = 1; l < NUM_LVL; l++)
         oh_d[l] = (fin_lvl == LVL_W'(l));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_q   <= '0;
         lvl_oh_o <= '0;
      end else begin
         priv_q   <= priv_d;
         lvl_oh_o <= oh_d;
      end
   end

   // R8: at most one line, never line 0
   a_r8_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lvl_oh_o) && !lvl_oh_o[0]);

   // R6: output never below the private level of the previous cycle
   a_r6_private_floor: assert property (@(posedge clk) disable iff (!rst_n)
      oh_to_idx(32'(lvl_oh_o)) >= int'($past(priv_lvl)));

   // R5: a non-target shows its private level only
   a_r5_non_target: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(is_tgt_i) == 1'b0) |-> (oh_to_idx(32'(lvl_oh_o)) == int'($past(priv_lvl))));

   // R7: a held timer bit keeps the level at least at the timer level
   a_r7_timer_floor: assert property (@(posedge clk) disable iff (!rst_n)
      priv_q[TIMER_LVL] |=> (oh_to_idx(32'(lvl_oh_o)) >= TIMER_LVL));

endmodule

// File: rtl/irq_level_router.sv
module irq_level_router #(
   parameter int                       NUM_CPU         = 4,
   parameter int                       CPU_W           = 4,
   parameter int                       NUM_SRC         = 32,
   parameter int                       LVL_W           = 4,
   parameter int                       TIMER_BIT       = 30,
   parameter bit                       USE_DEFAULT_MAP = 1'b1,
   parameter logic [NUM_SRC*LVL_W-1:0] SRC_LEVEL_MAP   = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_SRC-1:0]              src_in,
   input  logic [NUM_CPU-1:0]              tmr_in,
   input  logic                            wr_en,
   input  logic [1:0]                      wr_op,
   input  logic [CPU_W-1:0]                wr_cpu,
   input  logic [NUM_SRC-1:0]              wr_data,
   output logic [NUM_CPU*(1<<LVL_W)-1:0]   lvl_out
);
   import irq_rtr_pkg::*;

   localparam int NUM_LVL   = 1 << LVL_W;
   localparam int SOFT_BASE = NUM_SRC - (NUM_LVL - 1);
   localparam int TIMER_LVL = TIMER_BIT - SOFT_BASE + 1;

   if (NUM_CPU < 1 || NUM_CPU > (1 << CPU_W)) begin : g_chk_cpu
      $error("NUM_CPU out of range for CPU_W");
   end
   if (SOFT_BASE < 1) begin : g_chk_src
      $error("NUM_SRC too small for the private level field");
   end
   if (TIMER_BIT < SOFT_BASE || TIMER_BIT >= NUM_SRC) begin : g_chk_tmr
      $error("TIMER_BIT must lie in the private field");
   end

   wr_op_e           op;
   logic [CPU_W-1:0] tgt_q;
   logic [LVL_W-1:0] shr_lvl;
   logic             mask_we;

   assign op      = wr_op_e'(wr_op);
   assign mask_we = wr_en && (op == OP_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             tgt_q <= '0;
      else if (wr_en && (op == OP_TARGET))    tgt_q <= wr_data[CPU_W-1:0];
   end

   irq_shared_path #(
      .NUM_SRC(NUM_SRC), .LVL_W(LVL_W),
      .USE_DEFAULT_MAP(USE_DEFAULT_MAP), .SRC_LEVEL_MAP(SRC_LEVEL_MAP)
   ) u_shared (
      .clk(clk), .rst_n(rst_n), .src_i(src_in),
      .mask_we_i(mask_we), .wr_data_i(wr_data), .shr_lvl_o(shr_lvl)
   );

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic sel;
      assign sel = (wr_cpu == CPU_W'(c));
      irq_cpu_bank #(.LVL_W(LVL_W), .TIMER_LVL(TIMER_LVL)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .tmr_i(tmr_in[c]),
         .soft_set_i(wr_en && (op == OP_SOFT_SET) && sel),
         .soft_clr_i(wr_en && (op == OP_SOFT_CLR) && sel),
         .soft_data_i(wr_data[NUM_SRC-1:SOFT_BASE]),
         .is_tgt_i(tgt_q == CPU_W'(c)),
         .shr_lvl_i(shr_lvl),
         .lvl_oh_o(lvl_out[c*NUM_LVL +: NUM_LVL])
      );
   end

endmodule

// File: tb/irq_level_router_tb.sv
module irq_level_router_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 4;
   localparam int TB   = 30;
   localparam logic [31:0] SOFTM = 32'hFFFE_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic [3:0]  tmr = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_op = '0;
   logic [3:0]  wr_cpu = '0;
   logic [31:0] wr_data = '0;
   logic [63:0] lvl_out;

   int    n_chk = 0;
   int    n_fail = 0;
   string cur_req = "R1";

   irq_level_router u_dut (
      .clk(clk), .rst_n(rst_n), .src_in(src), .tmr_in(tmr),
      .wr_en(wr_en), .wr_op(wr_op), .wr_cpu(wr_cpu), .wr_data(wr_data),
      .lvl_out(lvl_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference
   logic [31:0] m_pend = '0;
   logic [31:0] m_mask = '0;
   int          m_tgt = 0;
   logic [31:0] m_cp [NCPU];
   logic [63:0] exp_out = '0;

   function automatic logic [63:0] model_out();
      logic [63:0] r;
      r = '0;
      for (int c = 0; c < NCPU; c++) begin
         int best;
         best = 0;
         for (int j = 17; j < 32; j++)
            if (m_cp[c][j] && (j - 16) > best) best = j - 16;
         if (c == m_tgt && !m_mask[31])
            for (int s = 0; s < 32; s++)
               if (m_pend[s] && !m_mask[s] && (s % 16) > best) best = s % 16;
         if (best > 0) r[c*16 + best] = 1'b1;
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_mask = '0; m_tgt = 0; exp_out = '0;
         for (int c = 0; c < NCPU; c++) m_cp[c] = '0;
      end else begin
         exp_out = model_out();
         for (int s = 0; s < 32; s++) m_pend[s] = src[s] && ((s % 16) != 0);
         if (wr_en && wr_op == 2'd0) m_mask = wr_data;
         if (wr_en && wr_op == 2'd1) m_tgt = int'(wr_data[3:0]);
         for (int c = 0; c < NCPU; c++) begin
            if (wr_en && wr_op == 2'd2 && int'(wr_cpu) == c) m_cp[c] = m_cp[c] | (wr_data & SOFTM);
            if (wr_en && wr_op == 2'd3 && int'(wr_cpu) == c) m_cp[c] = m_cp[c] & ~(wr_data & SOFTM);
            m_cp[c][TB] = tmr[c];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      chk(lvl_out == exp_out, cur_req, lvl_out, exp_out);
      for (int c = 0; c < NCPU; c++)
         chk($onehot0(lvl_out[c*16 +: 16]) && !lvl_out[c*16], "R8",
             {48'h0, lvl_out[c*16 +: 16]}, {48'h0, exp_out[c*16 +: 16]});
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] op, input logic [3:0] cpu, input logic [31:0] d);
      wr_en = 1'b1; wr_op = op; wr_cpu = cpu; wr_data = d;
      cyc(1);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R10 watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   int unsigned rng = 32'h1234_5678;
   function automatic int unsigned nxt(input int unsigned x);
      int unsigned y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   initial begin
      cur_req = "R1";
      cyc(3);
      chk(lvl_out == 64'h0, "R1", lvl_out, 64'h0);
      rst_n = 1'b1;
      cyc(3);
      chk(lvl_out == 64'h0, "R1", lvl_out, 64'h0);

      // R10: two-edge latency, target 0 after reset
      cur_req = "R10";
      src[5] = 1'b1;
      cyc(1);
      chk(lvl_out[15:0] == 16'h0, "R10", {48'h0, lvl_out[15:0]}, 64'h0);
      cyc(1);
      chk(lvl_out[15:0] == 16'h0020, "R10", {48'h0, lvl_out[15:0]}, 64'h20);
      src = '0;
      cyc(3);

      // R2: each source alone, including level-0 sources 0 and 16
      cur_req = "R2";
      for (int s = 0; s < 32; s++) begin
         src = 32'h1 << s;
         cyc(3);
      end
      src = 32'h0001_0001;
      cyc(3);
      chk(lvl_out == 64'h0, "R2", lvl_out, 64'h0);

      // R9: fall as sources are removed one by one
      cur_req = "R9";
      src = 32'hFFFF_FFFF;
      cyc(3);
      for (int s = 31; s >= 0; s--) begin
         src[s] = 1'b0;
         cyc(2);
      end

      // R3: mask patterns
      cur_req = "R3";
      src = 32'hFFFF_FFFF;
      wr(2'd0, 4'd0, 32'h0000_8000); cyc(2);
      wr(2'd0, 4'd0, 32'h7FFF_8000); cyc(2);
      wr(2'd0, 4'd0, 32'h7FFF_FFF0); cyc(2);
      wr(2'd0, 4'd0, 32'h0000_0000); cyc(2);

      // R4: master disable with a private level on cpu 0
      cur_req = "R4";
      wr(2'd2, 4'd0, 32'h0008_0000);
      wr(2'd0, 4'd0, 32'h8000_0000); cyc(3);
      chk(lvl_out[15:0] == 16'h0008, "R4", {48'h0, lvl_out[15:0]}, 64'h8);
      wr(2'd3, 4'd0, 32'h0008_0000);
      wr(2'd0, 4'd0, 32'h0); cyc(2);

      // R5: retarget, including out-of-range targets
      cur_req = "R5";
      for (int t = 1; t < 16; t++) begin
         wr(2'd1, 4'd0, 32'(t)); cyc(2);
      end
      chk(lvl_out == 64'h0, "R5", lvl_out, 64'h0);
      wr(2'd1, 4'd0, 32'd2); cyc(2);
      wr(2'd1, 4'd0, 32'd0); cyc(2);

      // R6: private soft bits against the shared level
      cur_req = "R6";
      src = 32'h0000_0100;
      for (int c = 0; c < NCPU; c++) begin
         wr(2'd2, 4'(c), 32'h1 << (18 + 3*c)); cyc(2);
      end
      wr(2'd2, 4'd0, 32'h8000_0000); cyc(2);
      wr(2'd3, 4'd0, 32'hFFFE_0000); cyc(2);
      for (int c = 1; c < NCPU; c++) begin
         wr(2'd3, 4'(c), 32'hFFFE_0000); cyc(2);
      end
      src = '0;

      // R7: timer inputs; soft writes to the timer bit ignored
      cur_req = "R7";
      tmr = 4'b0101; cyc(3);
      wr(2'd3, 4'd0, 32'h4000_0000); cyc(2);
      wr(2'd2, 4'd1, 32'h4000_0000); cyc(2);
      chk(lvl_out[31:16] == 16'h0, "R7", {48'h0, lvl_out[31:16]}, 64'h0);
      wr(2'd2, 4'd2, 32'h8000_0000); cyc(2);
      tmr = 4'b0000; cyc(3);
      wr(2'd3, 4'd2, 32'h8000_0000); cyc(2);

      // R11: soft writes to a nonexistent cpu
      cur_req = "R11";
      wr(2'd2, 4'd5, 32'hFFFE_0000); cyc(2);
      wr(2'd2, 4'd15, 32'hFFFE_0000); cyc(2);
      chk(lvl_out == 64'h0, "R11", lvl_out, 64'h0);

      // mixed: sources, timers and one write change in the same cycle (R5, R6)
      cur_req = "R5";
      for (int i = 0; i < 3000; i++) begin
         rng = nxt(rng); src = rng;
         rng = nxt(rng); tmr = rng[3:0];
         wr_en = rng[4]; wr_op = rng[6:5]; wr_cpu = {1'b0, rng[9:7]};
         rng = nxt(rng);
         wr_data = (wr_op == 2'd0) ? (rng & 32'h8FFF_FFFF) : rng;
         if (wr_op == 2'd0 && rng[3:0] == 4'h0) wr_data[31] = 1'b1;
         if (wr_op == 2'd1) wr_data[3:0] = {(rng[2:0] == 3'd0), 1'b0, rng[1:0]};
         if (i == 1500) cur_req = "R6";
         cyc(1);
      end
      wr_en = 1'b0;
      cyc(3);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule